// File: doc/BRIEF.md
# Symmetric Pre-Add Pipelined FIR Filter

This block is a fully parallel direct-form FIR filter with fixed, even-symmetric coefficients. Every cycle in which the input strobe is high, a signed sample enters a tap delay line. Samples at mirrored positions share a coefficient, so each such pair is summed before it reaches a multiplier. An odd tap count leaves a centre tap that is multiplied on its own. The products are then reduced by a binary adder tree. A register follows every adder stage and every multiplier stage, so one result can leave per clock.

Only the first half of the impulse response (plus the centre tap) is given, as a packed parameter. The second half is the mirror image. The result port is wide enough that no input pattern can overflow it. A valid strobe travels alongside the data with a fixed latency.

Top module: `fir_sym_pipe`

## Requirements
- R1: An asserted `rst_ni` (active low, asynchronous) clears the delay line and every pipeline register. While reset is held, `valid_o` and `y_o` read 0. After reset, responses contain no sample taken in before it.
- R2: A cycle with `valid_i` high shifts `x_i` (two's complement) into the delay line as the newest sample x(n).
- R3: A cycle with `valid_i` low leaves the delay line unchanged. The value on `x_i` in that cycle has no effect on any later output.
- R4: Each valid output equals the sum over k of h(k)*x(n-k), for k = 0..N_TAPS-1. Here h(k) = h(N_TAPS-1-k), and coefficient k (k < ceil(N_TAPS/2)) sits in `COEF_HALF` bits [k*COEF_W +: COEF_W] as a signed value.
- R5: Mirrored taps are pre-added and multiplied once. The impulse response is therefore the symmetric sequence h(0)..h(N_TAPS-1). With an odd N_TAPS, the centre coefficient appears exactly once.
- R6: `valid_o` is `valid_i` delayed by exactly 3 + ceil(log2(ceil(N_TAPS/2))) cycles, which is 5 cycles for the default 7 taps. `y_o` is the R4 result for that same sample.
- R7: With `valid_i` held high, a new correct result appears on every cycle once the pipeline has filled.
- R8: `y_o` is DATA_W+1+COEF_W+ceil(log2(ceil(N_TAPS/2))) bits wide. Full-scale inputs of either sign, including patterns whose signs match the coefficient signs, never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| x_i | input | DATA_W | Signed input sample |
| valid_o | output | 1 | Result strobe |
| y_o | output | OUT_W | Signed filter result |

## Verification
The hardest case to reach is the largest result magnitude. It needs every tap at full scale, with each sign matched to its coefficient, all at once. Random samples almost never produce that. The stimulus therefore feeds a directed sequence built from the coefficient signs, oldest tap first, so that the delay line lines up with the response. It also runs long stretches at the negative limit. Gapped random traffic carries junk on idle cycles to show that held taps stay untouched, and a reset in mid-stream followed by an impulse shows that no stale samples leak through.

// File: rtl/fir_pkg.sv
package fir_pkg;
  function automatic int half_taps(input int n);
    return (n + 1) / 2;
  endfunction

  function automatic int tree_levels(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction
endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DATA_W = 12,
  parameter int N_TAPS = 7
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  logic [DATA_W-1:0]                x_i,
  output logic [N_TAPS-1:0][DATA_W-1:0]    taps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taps_o <= '0;
    end else if (valid_i) begin
      for (int i = N_TAPS - 1; i > 0; i--) taps_o[i] <= taps_o[i-1];
      taps_o[0] <= x_i;
    end
  end

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> taps_o[0] == $past(x_i));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(taps_o));
endmodule

// File: rtl/fir_preadd.sv
module fir_preadd #(
  parameter int DATA_W = 12,
  parameter int N_TAPS = 7,
  localparam int NH = fir_pkg::half_taps(N_TAPS),
  localparam int SW = DATA_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_TAPS-1:0][DATA_W-1:0] taps_i,
  output logic [NH-1:0][SW-1:0]         pair_o
);
  localparam int NP = N_TAPS / 2;

  logic [NH-1:0][SW-1:0] sum_d;

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign sum_d[k] = SW'($signed(taps_i[k])) + SW'($signed(taps_i[N_TAPS-1-k]));
  end

  // odd length: centre tap passes alone
  if (N_TAPS % 2 == 1) begin : g_ctr
    assign sum_d[NH-1] = SW'($signed(taps_i[NP]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pair_o <= '0;
    else         pair_o <= sum_d;
  end
endmodule

// File: rtl/fir_mult.sv
module fir_mult #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 12,
  parameter int NH     = 4,
  parameter logic [NH*COEF_W-1:0] COEF_HALF = '0,
  localparam int SW     = DATA_W + 1,
  localparam int PROD_W = SW + COEF_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NH-1:0][SW-1:0]     pair_i,
  output logic [NH-1:0][PROD_W-1:0] prod_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
    end else begin
      for (int k = 0; k < NH; k++)
        prod_o[k] <= PROD_W'($signed(pair_i[k])) *
                     PROD_W'($signed(COEF_HALF[k*COEF_W +: COEF_W]));
    end
  end

  a_r4_zero_in_zero_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_i == '0) |=> (prod_o == '0));
endmodule

// File: rtl/fir_adder_tree.sv
module fir_adder_tree #(
  parameter int IN_W = 25,
  parameter int N_IN = 4,
  localparam int LVL   = fir_pkg::tree_levels(N_IN),
  localparam int OUT_W = IN_W + LVL
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IN-1:0][IN_W-1:0] in_i,
  output logic [OUT_W-1:0]        sum_o
);
  localparam int NP = 1 << LVL;

  logic signed [OUT_W-1:0] lvl0 [NP];

  always_comb begin
    for (int j = 0; j < NP; j++) begin
      lvl0[j] = '0;
      if (j < N_IN) lvl0[j] = OUT_W'($signed(in_i[j]));
    end
  end

  if (LVL == 0) begin : g_flat
    assign sum_o = lvl0[0];
  end else begin : g_tree
    logic signed [OUT_W-1:0] st [LVL][NP];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int l = 0; l < LVL; l++)
          for (int j = 0; j < NP; j++) st[l][j] <= '0;
      end else begin
        for (int j = 0; j < NP / 2; j++) st[0][j] <= lvl0[2*j] + lvl0[2*j+1];
        for (int l = 1; l < LVL; l++)
          for (int j = 0; j < (NP >> (l + 1)); j++)
            st[l][j] <= st[l-1][2*j] + st[l-1][2*j+1];
      end
    end

    assign sum_o = st[LVL-1][0];

    a_r8_no_wrap_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl0[0][OUT_W-1] && !lvl0[1][OUT_W-1]) |=> !st[0][0][OUT_W-1]);

    a_r8_no_wrap_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl0[0][OUT_W-1] && lvl0[1][OUT_W-1]) |=> st[0][0][OUT_W-1]);
  end
endmodule

// File: rtl/fir_sym_pipe.sv
module fir_sym_pipe #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 12,
  parameter int N_TAPS = 7,
  parameter logic [fir_pkg::half_taps(N_TAPS)*COEF_W-1:0] COEF_HALF = 48'h3FF_F74_019_FFD,
  localparam int NH    = fir_pkg::half_taps(N_TAPS),
  localparam int LVL   = fir_pkg::tree_levels(NH),
  localparam int OUT_W = DATA_W + 1 + COEF_W + LVL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  y_o
);
  localparam int SW     = DATA_W + 1;
  localparam int PROD_W = SW + COEF_W;
  localparam int LAT    = 3 + LVL;  // delay line, pre-add, multiply, tree levels

  logic [N_TAPS-1:0][DATA_W-1:0] taps;
  logic [NH-1:0][SW-1:0]         pair;
  logic [NH-1:0][PROD_W-1:0]     prod;
  logic [LAT-1:0]                vpipe;

  fir_delay_line #(.DATA_W(DATA_W), .N_TAPS(N_TAPS)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i), .taps_o(taps)
  );

  fir_preadd #(.DATA_W(DATA_W), .N_TAPS(N_TAPS)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .taps_i(taps), .pair_o(pair)
  );

  fir_mult #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NH(NH), .COEF_HALF(COEF_HALF)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .pair_i(pair), .prod_o(prod)
  );

  fir_adder_tree #(.IN_W(PROD_W), .N_IN(NH)) u_tree (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(prod), .sum_o(y_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vpipe <= '0;
    else         vpipe <= {vpipe[LAT-2:0], valid_i};
  end

  assign valid_o = vpipe[LAT-1];

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && y_o == '0));
endmodule

// File: tb/fir_sym_pipe_bench.sv
module fir_sym_pipe_bench;
  localparam int DW  = 12;
  localparam int CW  = 12;
  localparam int N   = 7;
  localparam int NH  = 4;
  localparam int LAT = 5;   // R6: 3 + ceil(log2(4))
  localparam int OW  = DW + 1 + CW + 2;
  localparam logic [NH*CW-1:0] HC = 48'h3FF_F74_019_FFD;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] x_i = '0;
  logic          valid_o;
  logic [OW-1:0] y_o;

  int n_chk = 0;
  int n_fail = 0;

  int     hist [N];
  longint my [LAT];
  bit     mv [LAT];

  always #2 clk = ~clk;

  fir_sym_pipe #(.DATA_W(DW), .COEF_W(CW), .N_TAPS(N), .COEF_HALF(HC)) u_fir_sym_pipe (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .valid_o(valid_o), .y_o(y_o)
  );

  function automatic int coef(input int i);
    int k;
    k = (i < NH) ? i : N - 1 - i;
    return int'($signed(HC[k*CW +: CW]));
  endfunction

  function automatic longint model_y();
    longint acc = 0;
    for (int k = 0; k < N; k++) acc += longint'(coef(k)) * longint'(hist[k]);
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < N; k++) hist[k] = 0;
    for (int i = 0; i < LAT; i++) begin mv[i] = 1'b0; my[i] = 0; end
  endtask

  // check current outputs, then drive one cycle
  task automatic step(input bit v, input logic [DW-1:0] x, input string tag);
    check(valid_o == mv[LAT-1], "R6 valid_o", longint'(valid_o), longint'(mv[LAT-1]));
    if (mv[LAT-1])
      check(longint'($signed(y_o)) == my[LAT-1], tag, longint'($signed(y_o)), my[LAT-1]);
    valid_i = v;
    x_i = x;
    if (v) begin
      for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'($signed(x));
    end
    for (int i = LAT - 1; i > 0; i--) begin mv[i] = mv[i-1]; my[i] = my[i-1]; end
    mv[0] = v;
    my[0] = v ? model_y() : 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    valid_i = 1'b0;
    clear_model();
    @(posedge clk);
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid_o in reset", longint'(valid_o), 0);
    check(y_o == '0, "R1 y_o in reset", longint'($signed(y_o)), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_model();
    @(negedge clk);
    do_reset();

    // R2 R5: impulse gives symmetric response, centre once
    step(1'b1, 12'sd100, "R2 R5 impulse");
    for (int i = 0; i < N + LAT; i++) step(1'b1, '0, "R2 R5 impulse");

    // R7: back-to-back random
    for (int i = 0; i < 40; i++) step(1'b1, DW'($urandom), "R7 back-to-back");

    // R3: gaps with junk on idle cycles
    for (int i = 0; i < 300; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, DW'($urandom), "R3 gapped");
    end

    // R8: negative full scale run
    for (int i = 0; i < N + 4; i++) step(1'b1, 12'h800, "R8 min run");
    // R8: signs matched to coefficients, oldest tap first
    for (int j = 0; j < N; j++)
      step(1'b1, (coef(N - 1 - j) < 0) ? 12'h800 : 12'h7FF, "R8 matched max");
    for (int j = 0; j < N; j++)
      step(1'b1, (coef(N - 1 - j) < 0) ? 12'h7FF : 12'h800, "R8 matched min");
    for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, "R8 drain");

    // R1: reset in mid-stream, then impulse sees no stale samples
    for (int i = 0; i < 10; i++) step(1'b1, DW'($urandom), "R4 pre-reset");
    do_reset();
    step(1'b1, 12'hF9C, "R1 post-reset impulse");
    for (int i = 0; i < N + LAT; i++) step(1'b1, '0, "R1 post-reset impulse");

    // R4: long random run, mostly valid
    for (int i = 0; i < 500; i++) begin
      bit v;
      v = ($urandom % 8) != 0;
      step(v, DW'($urandom), "R4 random");
    end
    for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, "R4 drain");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule